// File: doc/BRIEF.md
# PWM Action Qualifier With Software Force

This block sits between a PWM time base and the output pins. Each clock it receives strobes that say the counter has reached zero, reached its period, or matched one of two compare values, together with the current count direction and the counting mode. For each of its two outputs it looks up a two-bit action for every strobe that fired. When several strobes fire together, a mode-dependent priority picks one action, which then sets, clears, toggles or keeps the output level.

Software has two extra controls per output. A one-shot request applies an action exactly once, one clock after it is strobed, and outranks every event in that cycle. A continuous hold pins the output low or high for as long as it is set. While the hold is active, events and one-shot requests are ignored. The output keeps the held level after the hold is released. Both outputs have fully separate configuration. The raw levels are meant to feed later dead-band and trip stages, which are not part of this block.

Top module: `aq_dual_qualifier`

## Requirements
- R1: While `rst_n` is low, both outputs are 0, and this takes effect without waiting for a clock edge. Internally the reset is released in step with the clock.
- R2: Action codes are 00 keep, 01 drive low, 10 drive high and 11 toggle. The selected action takes effect at the rising edge where the event strobe is sampled high. With no event, no one-shot and no hold, the output is unchanged.
- R3: Each output's configuration word is split into these fields: [1:0] zero action, [3:2] period action, [5:4] compare-A while counting up, [7:6] compare-A while counting down, [9:8] compare-B while counting up, [11:10] compare-B while counting down. The compare fields are chosen by `cnt_up` (1 = counting up).
- R4: Outputs A and B use only their own configuration word, one-shot inputs and hold input. Events configured for one output leave the other output unchanged.
- R5: In up mode (`cnt_mode` 00), the priority from highest to lowest is period, compare-B, compare-A, zero.
- R6: In down mode (`cnt_mode` 01), the priority from highest to lowest is zero, compare-B, compare-A, period.
- R7: In up-down mode (`cnt_mode` 10, and also 11), the priority from highest to lowest is compare-B, compare-A, zero, period.
- R8: A firing event whose action code is 00 does not mask a lower-priority event that fires in the same cycle.
- R9: A one-shot request sampled at edge k applies its action at edge k+1 and only there. The request then clears itself.
- R10: A pending one-shot action other than 00 outranks every event action in the cycle where it applies.
- R11: Hold code 01 forces the output low and 10 forces it high from the next edge; 00 and 11 mean no hold. A hold overrides events and one-shot requests, and a one-shot request that falls due during a hold is discarded. The held level remains after the hold is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_mode | input | 2 | Counting mode: 00 up, 01 down, 10/11 up-down |
| cnt_up | input | 1 | Current count direction, 1 = up |
| ev_zero | input | 1 | Counter-equals-zero strobe |
| ev_period | input | 1 | Counter-equals-period strobe |
| ev_cmpa | input | 1 | Counter-equals-compare-A strobe |
| ev_cmpb | input | 1 | Counter-equals-compare-B strobe |
| act_cfg_a | input | 12 | Event action word for output A |
| act_cfg_b | input | 12 | Event action word for output B |
| os_req_a | input | 1 | One-shot request strobe for A |
| os_act_a | input | 2 | One-shot action code for A |
| os_req_b | input | 1 | One-shot request strobe for B |
| os_act_b | input | 2 | One-shot action code for B |
| hold_a | input | 2 | Continuous hold code for A |
| hold_b | input | 2 | Continuous hold code for B |
| pwm_a | output | 1 | Raw PWM level A |
| pwm_b | output | 1 | Raw PWM level B |

## Verification
The hardest cases to reach are simultaneous events in each mode, where two candidate actions would give different levels. A result only proves which event won if the starting level is chosen so that the two actions disagree. The bench therefore uses a hold pulse to preset each output to a known level before it fires each pair of strobes from a table. A second hard case is a one-shot request that falls due while a hold is active. To reach it, the bench issues the request under hold, releases the hold one cycle after the discard, and only then checks that the held level remains.

// File: rtl/aq_pkg.sv
package aq_pkg;

  localparam int ACT_W  = 2;
  localparam int NUM_EV = 4;
  localparam int N_CH   = 2;
  localparam int CFG_W  = 6 * ACT_W;

  typedef enum logic [ACT_W-1:0] {
    AQ_KEEP   = 2'b00,
    AQ_LOW    = 2'b01,
    AQ_HIGH   = 2'b10,
    AQ_TOGGLE = 2'b11
  } aq_act_e;

  typedef enum logic [1:0] {
    AQ_MODE_UP   = 2'b00,
    AQ_MODE_DOWN = 2'b01,
    AQ_MODE_UD   = 2'b10,
    AQ_MODE_UD2  = 2'b11
  } aq_mode_e;

  localparam logic [1:0] HOLD_LOW  = 2'b01;
  localparam logic [1:0] HOLD_HIGH = 2'b10;

  // field order from MSB: cmpb down, cmpb up, cmpa down, cmpa up, period, zero
  typedef struct packed {
    aq_act_e cb_dn;
    aq_act_e cb_up;
    aq_act_e ca_dn;
    aq_act_e ca_up;
    aq_act_e prd;
    aq_act_e zro;
  } aq_cfg_t;

  function automatic logic aq_apply(input aq_act_e act, input logic cur);
    logic r;
    case (act)
      AQ_LOW:    r = 1'b0;
      AQ_HIGH:   r = 1'b1;
      AQ_TOGGLE: r = ~cur;
      default:   r = cur;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/aq_rst_sync.sv
module aq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/aq_event_sel.sv
module aq_event_sel
  import aq_pkg::*;
(
  input  logic     [1:0] cnt_mode,
  input  logic           cnt_up,
  input  logic           ev_zero,
  input  logic           ev_period,
  input  logic           ev_cmpa,
  input  logic           ev_cmpb,
  input  aq_cfg_t        cfg,
  output aq_act_e        ev_act
);
  aq_act_e code_zro, code_prd, code_ca, code_cb;
  logic    slot_v [NUM_EV];
  aq_act_e slot_c [NUM_EV];
  aq_act_e win;

  // direction picks which compare code applies
  always_comb begin
    code_zro = cfg.zro;
    code_prd = cfg.prd;
    code_ca  = cnt_up ? cfg.ca_up : cfg.ca_dn;
    code_cb  = cnt_up ? cfg.cb_up : cfg.cb_dn;
  end

  // slot 0 is the highest priority for the current mode
  always_comb begin
    case (aq_mode_e'(cnt_mode))
      AQ_MODE_UP: begin
        slot_v[0] = ev_period; slot_c[0] = code_prd;
        slot_v[1] = ev_cmpb;   slot_c[1] = code_cb;
        slot_v[2] = ev_cmpa;   slot_c[2] = code_ca;
        slot_v[3] = ev_zero;   slot_c[3] = code_zro;
      end
      AQ_MODE_DOWN: begin
        slot_v[0] = ev_zero;   slot_c[0] = code_zro;
        slot_v[1] = ev_cmpb;   slot_c[1] = code_cb;
        slot_v[2] = ev_cmpa;   slot_c[2] = code_ca;
        slot_v[3] = ev_period; slot_c[3] = code_prd;
      end
      default: begin
        slot_v[0] = ev_cmpb;   slot_c[0] = code_cb;
        slot_v[1] = ev_cmpa;   slot_c[1] = code_ca;
        slot_v[2] = ev_zero;   slot_c[2] = code_zro;
        slot_v[3] = ev_period; slot_c[3] = code_prd;
      end
    endcase
  end

  // scan from lowest to highest so the highest active non-keep code remains
  always_comb begin
    win = AQ_KEEP;
    for (int i = NUM_EV - 1; i >= 0; i--) begin
      if (slot_v[i] && (slot_c[i] != AQ_KEEP)) begin
        win = slot_c[i];
      end
    end
  end

  assign ev_act = win;
endmodule

// File: rtl/aq_oneshot.sv
module aq_oneshot
  import aq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic [ACT_W-1:0] req_act,
  output logic             pend,
  output aq_act_e          pend_act
);
  logic    pend_q, pend_d;
  aq_act_e act_q, act_d;
  logic    act_en;

  always_comb begin
    pend_d = req;
    act_d  = aq_act_e'(req_act);
    act_en = req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      act_q  <= AQ_KEEP;
    end else begin
      pend_q <= pend_d;
      if (act_en) begin
        act_q <= act_d;
      end
    end
  end

  assign pend     = pend_q;
  assign pend_act = act_q;
endmodule

// File: rtl/aq_out_stage.sv
module aq_out_stage
  import aq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] hold,
  input  logic       os_pend,
  input  aq_act_e    os_act,
  input  aq_act_e    ev_act,
  output logic       level
);
  aq_act_e sel;
  logic    lvl_q, lvl_d, lvl_en;

  always_comb begin
    sel = (os_pend && (os_act != AQ_KEEP)) ? os_act : ev_act;
    if (hold == HOLD_LOW) begin
      lvl_en = 1'b1;
      lvl_d  = 1'b0;
    end else if (hold == HOLD_HIGH) begin
      lvl_en = 1'b1;
      lvl_d  = 1'b1;
    end else begin
      lvl_en = (sel != AQ_KEEP);
      lvl_d  = aq_apply(sel, lvl_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
    end else if (lvl_en) begin
      lvl_q <= lvl_d;
    end
  end

  assign level = lvl_q;
endmodule

// File: rtl/aq_dual_qualifier.sv
module aq_dual_qualifier
  import aq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cnt_mode,
  input  logic             cnt_up,
  input  logic             ev_zero,
  input  logic             ev_period,
  input  logic             ev_cmpa,
  input  logic             ev_cmpb,
  input  logic [CFG_W-1:0] act_cfg_a,
  input  logic [CFG_W-1:0] act_cfg_b,
  input  logic             os_req_a,
  input  logic [ACT_W-1:0] os_act_a,
  input  logic             os_req_b,
  input  logic [ACT_W-1:0] os_act_b,
  input  logic [1:0]       hold_a,
  input  logic [1:0]       hold_b,
  output logic             pwm_a,
  output logic             pwm_b
);
  logic             rst_sync_n;
  aq_cfg_t          ch_cfg  [N_CH];
  logic             ch_req  [N_CH];
  logic [ACT_W-1:0] ch_ract [N_CH];
  logic [1:0]       ch_hold [N_CH];
  logic             ch_lvl  [N_CH];

  always_comb begin
    ch_cfg[0]  = act_cfg_a;  ch_cfg[1]  = act_cfg_b;
    ch_req[0]  = os_req_a;   ch_req[1]  = os_req_b;
    ch_ract[0] = os_act_a;   ch_ract[1] = os_act_b;
    ch_hold[0] = hold_a;     ch_hold[1] = hold_b;
  end

  aq_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    aq_act_e ev_act;
    logic    os_pend;
    aq_act_e os_act;

    aq_event_sel u_sel (
      .cnt_mode  (cnt_mode),
      .cnt_up    (cnt_up),
      .ev_zero   (ev_zero),
      .ev_period (ev_period),
      .ev_cmpa   (ev_cmpa),
      .ev_cmpb   (ev_cmpb),
      .cfg       (ch_cfg[c]),
      .ev_act    (ev_act)
    );

    aq_oneshot u_os (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .req      (ch_req[c]),
      .req_act  (ch_ract[c]),
      .pend     (os_pend),
      .pend_act (os_act)
    );

    aq_out_stage u_out (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .hold    (ch_hold[c]),
      .os_pend (os_pend),
      .os_act  (os_act),
      .ev_act  (ev_act),
      .level   (ch_lvl[c])
    );
  end

  assign pwm_a = ch_lvl[0];
  assign pwm_b = ch_lvl[1];
endmodule

// File: rtl/aq_dual_qualifier_chk.sv
module aq_dual_qualifier_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rst_s_n,
  input logic        ev_zero,
  input logic        ev_period,
  input logic        ev_cmpa,
  input logic        ev_cmpb,
  input logic [11:0] act_cfg_a,
  input logic        os_req_a,
  input logic [1:0]  os_act_a,
  input logic [1:0]  hold_a,
  input logic [1:0]  hold_b,
  input logic        pwm_a,
  input logic        pwm_b
);
  logic       req_d;
  logic [1:0] ract_d;
  logic       any_ev, free_a;

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      req_d  <= 1'b0;
      ract_d <= 2'b00;
    end else begin
      req_d  <= os_req_a;
      ract_d <= os_act_a;
    end
  end

  assign any_ev = ev_zero | ev_period | ev_cmpa | ev_cmpb;
  assign free_a = (hold_a != 2'b01) && (hold_a != 2'b10);

  // R1: outputs low whenever reset is applied
  p_reset_low_r1: assert property (@(posedge clk) !rst_n |-> (!pwm_a && !pwm_b));

  // R2: nothing to do keeps the level
  p_idle_keep_r2: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!any_ev && !req_d && free_a) |=> $stable(pwm_a));

  // R2/R3: lone zero event with drive-high code
  p_zero_high_r3: assert property (@(posedge clk) disable iff (!rst_s_n)
    (ev_zero && !ev_period && !ev_cmpa && !ev_cmpb && !req_d && free_a
     && act_cfg_a[1:0] == 2'b10) |=> pwm_a);

  // R9/R10: a due one-shot high request wins
  p_oneshot_high_r10: assert property (@(posedge clk) disable iff (!rst_s_n)
    (req_d && ract_d == 2'b10 && free_a) |=> pwm_a);

  // R11: hold codes force the level
  p_hold_low_r11: assert property (@(posedge clk) disable iff (!rst_s_n)
    (hold_a == 2'b01) |=> !pwm_a);
  p_hold_high_r11: assert property (@(posedge clk) disable iff (!rst_s_n)
    (hold_b == 2'b10) |=> pwm_b);
endmodule

bind aq_dual_qualifier aq_dual_qualifier_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rst_s_n   (rst_sync_n),
  .ev_zero   (ev_zero),
  .ev_period (ev_period),
  .ev_cmpa   (ev_cmpa),
  .ev_cmpb   (ev_cmpb),
  .act_cfg_a (act_cfg_a),
  .os_req_a  (os_req_a),
  .os_act_a  (os_act_a),
  .hold_a    (hold_a),
  .hold_b    (hold_b),
  .pwm_a     (pwm_a),
  .pwm_b     (pwm_b)
);

// File: tb/aq_dual_qualifier_bench.sv
module aq_dual_qualifier_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  cnt_mode;
  logic        cnt_up;
  logic        ev_zero, ev_period, ev_cmpa, ev_cmpb;
  logic [11:0] act_cfg_a, act_cfg_b;
  logic        os_req_a, os_req_b;
  logic [1:0]  os_act_a, os_act_b;
  logic [1:0]  hold_a, hold_b;
  logic        pwm_a, pwm_b;
  int          n_chk = 0;
  int          n_fail = 0;

  always #10 clk = ~clk;

  aq_dual_qualifier u_aq_dual_qualifier (.*);

  // fields: cb_dn=keep, cb_up=toggle, ca_dn=high, ca_up=low, prd=low, zro=high
  localparam logic [11:0] CFG_T = 12'h396;

  // {mode[1:0], up, zero, period, cmpa, cmpb, start, expect}
  localparam int NV = 19;
  localparam logic [8:0] VEC [NV] = '{
    9'b00_1_1000_0_1, 9'b00_1_0100_1_0, 9'b00_1_0010_1_0, 9'b10_0_0010_0_1,
    9'b00_1_0001_0_1, 9'b00_1_0001_1_0, 9'b10_0_0001_1_1, 9'b00_1_1010_0_0,
    9'b01_0_1010_0_1, 9'b10_1_1001_1_0, 9'b10_0_1001_0_1, 9'b00_1_1100_1_0,
    9'b01_0_1100_0_1, 9'b10_0_0110_0_1, 9'b00_1_0000_1_1, 9'b11_0_0110_0_1,
    9'b01_1_0011_0_1, 9'b00_1_0011_0_1, 9'b00_1_0101_0_0
  };
  // requirement number per row
  localparam int VREQ [NV] = '{2, 2, 3, 3, 2, 2, 3, 5, 6, 7, 8, 5, 6, 7, 2, 7, 6, 5, 5};

  function automatic string req_name(input int n);
    case (n)
      2: return "R2";
      3: return "R3";
      5: return "R5";
      6: return "R6";
      7: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input logic act, input logic exp, input string tag, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  // preset both levels through a one-cycle hold, ends at a falling edge with hold released
  task automatic preset(input logic la, input logic lb);
    @(negedge clk);
    hold_a = la ? 2'b10 : 2'b01;
    hold_b = lb ? 2'b10 : 2'b01;
    @(posedge clk);
    @(negedge clk);
    hold_a = 2'b00;
    hold_b = 2'b00;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [8:0] v;
    rst_n = 1'b0;
    cnt_mode = 2'b00; cnt_up = 1'b1;
    ev_zero = 0; ev_period = 0; ev_cmpa = 0; ev_cmpb = 0;
    act_cfg_a = '0; act_cfg_b = '0;
    os_req_a = 0; os_req_b = 0; os_act_a = 0; os_act_b = 0;
    hold_a = 0; hold_b = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(pwm_a, 1'b0, "R1", "reset level A");
    check(pwm_b, 1'b0, "R1", "reset level B");
    rst_n = 1'b1;
    repeat (4) tick();

    // table walk: output A from a preset level, B configured to keep everything
    for (int k = 0; k < NV; k++) begin
      v = VEC[k];
      preset(v[1], v[1]);
      cnt_mode  = v[8:7];
      cnt_up    = v[6];
      ev_zero   = v[5];
      ev_period = v[4];
      ev_cmpa   = v[3];
      ev_cmpb   = v[2];
      act_cfg_a = CFG_T;
      act_cfg_b = 12'h000;
      @(posedge clk);
      @(negedge clk);
      ev_zero = 0; ev_period = 0; ev_cmpa = 0; ev_cmpb = 0;
      check(pwm_a, v[0], req_name(VREQ[k]), $sformatf("row %0d output A", k));
      check(pwm_b, v[1], "R4", $sformatf("row %0d output B untouched", k));
    end

    // R9: one-shot toggle lands one edge late, then clears itself
    cnt_mode = 2'b00; cnt_up = 1'b1;
    act_cfg_a = 12'h000;
    preset(1'b0, 1'b0);
    os_req_a = 1; os_act_a = 2'b11;
    tick();
    os_req_a = 0;
    check(pwm_a, 1'b0, "R9", "one-shot not yet applied");
    tick();
    check(pwm_a, 1'b1, "R9", "one-shot applied");
    tick();
    check(pwm_a, 1'b1, "R9", "one-shot self-cleared");

    // R10: due one-shot high beats a zero event with drive-low
    act_cfg_a = 12'h001;
    preset(1'b1, 1'b0);
    os_req_a = 1; os_act_a = 2'b10;
    tick();
    os_req_a = 0; ev_zero = 1;
    tick();
    ev_zero = 0;
    check(pwm_a, 1'b1, "R10", "one-shot outranks event");

    // R11: hold overrides events; code 11 means no hold
    act_cfg_a = 12'h002;
    hold_a = 2'b01; ev_zero = 1;
    tick();
    check(pwm_a, 1'b0, "R11", "hold low over drive-high event");
    act_cfg_a = 12'h001; hold_a = 2'b10;
    tick();
    check(pwm_a, 1'b1, "R11", "hold high over drive-low event");
    hold_a = 2'b11;
    tick();
    ev_zero = 0; hold_a = 2'b00;
    check(pwm_a, 1'b0, "R11", "code 11 lets event act");

    // R11: one-shot due under hold is discarded, level kept after release
    hold_a = 2'b01; os_req_a = 1; os_act_a = 2'b10;
    tick();
    os_req_a = 0;
    tick();
    hold_a = 2'b00;
    tick();
    check(pwm_a, 1'b0, "R11", "one-shot discarded under hold");
    tick();
    check(pwm_a, 1'b0, "R11", "held level retained");

    // R4: events and one-shot on B leave A alone
    act_cfg_a = 12'h000; act_cfg_b = 12'h003;
    preset(1'b0, 1'b0);
    ev_zero = 1;
    tick();
    ev_zero = 0;
    check(pwm_b, 1'b1, "R4", "B toggled by own config");
    check(pwm_a, 1'b0, "R4", "A unchanged by B config");
    os_req_b = 1; os_act_b = 2'b01;
    tick();
    os_req_b = 0;
    tick();
    check(pwm_b, 1'b0, "R4", "B one-shot low");
    check(pwm_a, 1'b0, "R4", "A unchanged by B one-shot");

    // R1: reset mid-run clears without a clock edge
    preset(1'b1, 1'b1);
    tick();
    check(pwm_a, 1'b1, "R11", "preset high A before reset");
    #3 rst_n = 1'b0;
    #1;
    check(pwm_a, 1'b0, "R1", "async reset A");
    check(pwm_b, 1'b0, "R1", "async reset B");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) tick();

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule